// File: doc/BRIEF.md
# Packed Single-to-Double Widening Unit

This block turns a vector of packed 32-bit IEEE-754 single-precision values into 64-bit double-precision lanes of a destination register up to 512 bits wide. Each lane is widened exactly. Normal values are rebiased. Subnormal values are renormalised into double normals. Zeros, infinities and NaNs keep their sign, and NaN payloads are carried over. The source can be a full vector, or its lowest 32-bit element can be broadcast to every lane.

The unit combines the widened lanes with the previous destination value. How it does so depends on an encoding class. The legacy class writes two lanes and keeps every bit above them. The plain class writes 2, 4 or 8 lanes and clears everything above them. The masked class also writes 2, 4 or 8 lanes, but only where the lane's writemask bit is set. Unselected lanes are either zeroed or kept, and everything above the vector length is cleared.

A malformed encoding raises a flag and leaves the destination equal to the old value. The datapath is combinational, followed by one register stage, so results arrive one cycle after `in_valid`.

Top module: `fpw_widen_unit`

## Requirements
- R1: Lane i of the source (`src[32i+31:32i]`) is converted into `new_dst[64i+63:64i]`. The number of written lanes is 2 for the legacy class (`enc_cls`=0) and ignores `vec_len`. For the plain (`enc_cls`=1) and masked (`enc_cls`=2) classes it is 2, 4 or 8 for `vec_len` 0, 1 or 2.
- R2: A normal single input gives a double with the same sign, exponent increased by 896, and the 23 fraction bits placed at the top of the 52-bit fraction, with zeros below.
- R3: A subnormal single input gives the exact double normal: the leading one becomes the hidden bit, and the exponent is 896 minus the number of leading zeros in the 23-bit fraction.
- R4: A signed zero gives a signed zero, and a signed infinity gives a signed infinity.
- R5: A NaN gives a double NaN with the quiet bit (bit 51) set and the remaining 22 payload bits at the top of the fraction below it. `invalid_op` is 1 when a written lane holds a signalling NaN (single fraction bit 22 clear), and 0 otherwise.
- R6: When `bcast` is 1, `src[31:0]` is converted into every written lane and the other source bits are ignored.
- R7: In the masked class, a lane within the vector length takes the converted value when its `wmask` bit is 1. When its `wmask` bit is 0, it becomes zero if `zero_en` is 1 and keeps its `old_dst` value if `zero_en` is 0.
- R8: In the legacy and plain classes, `wmask` and `zero_en` have no effect, and every lane within the vector length is written.
- R9: In the plain and masked classes, every destination bit above the vector length is 0.
- R10: In the legacy class, `new_dst[511:128]` equals `old_dst[511:128]`.
- R11: `bad_enc` is 1, `new_dst` equals `old_dst` and `invalid_op` is 0 in any of these cases: `spec_fld` is not 4'b1111 for the plain or masked class, `enc_cls` is 3, or `vec_len` is 3 outside the legacy class. The legacy class ignores `spec_fld`.
- R12: Outputs are registered. `out_valid` is 1 exactly in the cycle after each cycle with `in_valid` high. `new_dst`, `bad_enc` and `invalid_op` change only then and hold otherwise. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operands are valid this cycle |
| src | input | 256 | Packed single-precision source lanes |
| bcast | input | 1 | Broadcast `src[31:0]` to all lanes |
| vec_len | input | 2 | 0: 128-bit, 1: 256-bit, 2: 512-bit destination length |
| enc_cls | input | 2 | 0 legacy, 1 plain, 2 masked, 3 reserved |
| spec_fld | input | 4 | Unused register-specifier field, must be 4'b1111 |
| wmask | input | 8 | Per-lane writemask (masked class) |
| zero_en | input | 1 | Zero unselected lanes instead of merging |
| old_dst | input | 512 | Previous destination value |
| out_valid | output | 1 | Results are valid |
| new_dst | output | 512 | New destination value |
| bad_enc | output | 1 | Invalid encoding detected |
| invalid_op | output | 1 | Signalling NaN converted in a written lane |

## Verification
Every result (`new_dst`, `bad_enc`, `invalid_op` and `out_valid`) is due at the first rising edge after the cycle in which `in_valid` is high. The bench drives operands on a falling edge and holds `in_valid` for exactly one cycle. It samples at the following falling edge, half a period after the register has loaded. It then waits one more cycle and checks that `out_valid` has dropped and that `new_dst` has held its value.

// File: rtl/fpw_pkg.sv
// Package fpw_pkg
// Shared encodings and helpers for the widening unit.
// Assumes: single precision is 32 bits wide and double precision is 64 bits wide.
package fpw_pkg;
    typedef enum logic [1:0] {
        CLS_LEGACY = 2'd0,
        CLS_PLAIN  = 2'd1,
        CLS_MASKED = 2'd2,
        CLS_RSVD   = 2'd3
    } enc_cls_e;

    localparam int SP_W       = 32;
    localparam int DP_W       = 64;
    localparam int SP_FRAC_W  = 23;
    localparam int DP_FRAC_W  = 52;
    localparam int FRAC_PAD   = DP_FRAC_W - SP_FRAC_W;
    localparam logic [10:0] REBIAS = 11'd896;

    // Count the zeros above the most significant one of a 23-bit fraction.
    function automatic logic [4:0] lead_zeros23(input logic [SP_FRAC_W-1:0] v);
        logic [4:0] n;
        logic       seen;
        n    = 5'd0;
        seen = 1'b0;
        for (int i = SP_FRAC_W - 1; i >= 0; i--) begin
            if (!seen && v[i]) seen = 1'b1;
            else if (!seen)    n = n + 5'd1;
        end
        return n;
    endfunction
endpackage

// File: rtl/fpw_sp2dp.sv
// Module fpw_sp2dp
// Exact combinational widening of one single-precision value to double precision.
// Assumes: no denormals-are-zero handling; NaNs are always returned quiet.
module fpw_sp2dp
    import fpw_pkg::*;
(
    input  logic [SP_W-1:0] sp_i,
    output logic [DP_W-1:0] dp_o,
    output logic            snan_o
);
    logic                 sgn;
    logic [7:0]           ex;
    logic [SP_FRAC_W-1:0] fr;
    logic [4:0]           lz;
    logic [SP_FRAC_W-1:0] norm_fr;

    assign sgn = sp_i[31];
    assign ex  = sp_i[30:23];
    assign fr  = sp_i[22:0];
    assign lz  = lead_zeros23(fr);
    // Shift the subnormal fraction so that its leading one drops out as the hidden bit.
    assign norm_fr = fr << (lz + 5'd1);

    // Select the widened encoding according to the input class.
    always_comb begin
        snan_o = 1'b0;
        if (ex == 8'd0) begin
            if (fr == '0) dp_o = {sgn, 63'd0};
            else          dp_o = {sgn, REBIAS - {6'd0, lz}, norm_fr, {FRAC_PAD{1'b0}}};
        end else if (ex == 8'hFF) begin
            if (fr == '0) dp_o = {sgn, 11'h7FF, {DP_FRAC_W{1'b0}}};
            else begin
                dp_o   = {sgn, 11'h7FF, 1'b1, fr[21:0], {FRAC_PAD{1'b0}}};
                snan_o = ~fr[22];
            end
        end else begin
            dp_o = {sgn, REBIAS + {3'd0, ex}, fr, {FRAC_PAD{1'b0}}};
        end
    end

    // A nonzero input never yields a double with a zero exponent field.
    always_comb begin
        if (sp_i[30:0] != '0)
            assert_no_dp_subnormal_R3: assert (dp_o[62:52] != 11'd0);
    end
endmodule

// File: rtl/fpw_lane_sel.sv
// Module fpw_lane_sel
// Chooses one destination lane from the converted value, the old value or zero.
// Assumes: the lane's active, class and encoding-error controls are decided by the parent.
module fpw_lane_sel
    import fpw_pkg::*;
(
    input  logic [DP_W-1:0] conv_i,
    input  logic [DP_W-1:0] old_i,
    input  logic            active_i,
    input  logic            keep_upper_i,
    input  logic            masked_i,
    input  logic            mbit_i,
    input  logic            zero_i,
    input  logic            bad_i,
    output logic [DP_W-1:0] lane_o,
    output logic            wr_o
);
    // Apply the masking, merging and upper-bit policy for this lane.
    always_comb begin
        wr_o = 1'b0;
        if (bad_i) begin
            lane_o = old_i;
        end else if (active_i && (!masked_i || mbit_i)) begin
            lane_o = conv_i;
            wr_o   = 1'b1;
        end else if (active_i) begin
            lane_o = zero_i ? '0 : old_i;
        end else begin
            lane_o = keep_upper_i ? old_i : '0;
        end
    end
endmodule

// File: rtl/fpw_widen_unit.sv
// Module fpw_widen_unit
// Packed single-to-double widening with broadcast, writemask and class-dependent
// upper-bit policy. There is one register stage, so the latency is a fixed single cycle.
// Assumes: LANES_MAX is 2, 4 or 8; enc_cls and spec_fld come from an external decoder.
module fpw_widen_unit
    import fpw_pkg::*;
#(
    parameter int LANES_MAX = 8,
    localparam int SRC_W    = LANES_MAX * SP_W,
    localparam int DST_W    = LANES_MAX * DP_W,
    localparam int LEG_LN   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [SRC_W-1:0] src,
    input  logic             bcast,
    input  logic [1:0]       vec_len,
    input  logic [1:0]       enc_cls,
    input  logic [3:0]       spec_fld,
    input  logic [LANES_MAX-1:0] wmask,
    input  logic             zero_en,
    input  logic [DST_W-1:0] old_dst,
    output logic             out_valid,
    output logic [DST_W-1:0] new_dst,
    output logic             bad_enc,
    output logic             invalid_op
);
    enc_cls_e             cls;
    logic [4:0]           n_act;
    logic                 bad_nxt;
    logic [DST_W-1:0]     dst_nxt;
    logic [LANES_MAX-1:0] snan_v;
    logic [LANES_MAX-1:0] wr_v;

    assign cls = enc_cls_e'(enc_cls);

    // Work out the active lane count and whether the encoding is malformed.
    always_comb begin
        n_act   = (cls == CLS_LEGACY) ? 5'(LEG_LN) : (5'd2 << vec_len);
        bad_nxt = 1'b0;
        if (cls == CLS_RSVD) bad_nxt = 1'b1;
        else if (cls != CLS_LEGACY &&
                 (spec_fld != 4'hF || {27'd0, n_act} > LANES_MAX)) bad_nxt = 1'b1;
    end

    for (genvar g = 0; g < LANES_MAX; g++) begin : g_lane
        logic [SP_W-1:0] sp_in;
        logic [DP_W-1:0] dp_cv;
        logic            sn;

        assign sp_in = bcast ? src[SP_W-1:0] : src[g*SP_W +: SP_W];

        fpw_sp2dp u_cvt (
            .sp_i   (sp_in),
            .dp_o   (dp_cv),
            .snan_o (sn)
        );

        fpw_lane_sel u_sel (
            .conv_i       (dp_cv),
            .old_i        (old_dst[g*DP_W +: DP_W]),
            .active_i     (g < n_act),
            .keep_upper_i (cls == CLS_LEGACY),
            .masked_i     (cls == CLS_MASKED),
            .mbit_i       (wmask[g]),
            .zero_i       (zero_en),
            .bad_i        (bad_nxt),
            .lane_o       (dst_nxt[g*DP_W +: DP_W]),
            .wr_o         (wr_v[g])
        );

        assign snan_v[g] = sn & wr_v[g];
    end

    // Output register: capture results on every valid operand cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            new_dst    <= '0;
            bad_enc    <= 1'b0;
            invalid_op <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                new_dst    <= dst_nxt;
                bad_enc    <= bad_nxt;
                invalid_op <= |snan_v;
            end
        end
    end

    assert_valid_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_hold_when_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(new_dst));
    assert_bad_keeps_old_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls == CLS_PLAIN && spec_fld != 4'hF) |=> (bad_enc && new_dst == $past(old_dst)));
    assert_legacy_upper_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls == CLS_LEGACY) |=> new_dst[DST_W-1:LEG_LN*DP_W] == $past(old_dst[DST_W-1:LEG_LN*DP_W]));
    assert_plain_upper_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cls == CLS_PLAIN && spec_fld == 4'hF && vec_len == 2'd0)
        |=> new_dst[DST_W-1:LEG_LN*DP_W] == '0);
endmodule

// File: tb/test_fpw_widen_unit.sv
module test_fpw_widen_unit;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [255:0] src = '0;
    logic         bcast = 1'b0;
    logic [1:0]   vec_len = '0;
    logic [1:0]   enc_cls = '0;
    logic [3:0]   spec_fld = 4'hF;
    logic [7:0]   wmask = '0;
    logic         zero_en = 1'b0;
    logic [511:0] old_dst = '0;
    logic         out_valid;
    logic [511:0] new_dst;
    logic         bad_enc;
    logic         invalid_op;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fpw_widen_unit i_fpw_widen_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src(src), .bcast(bcast),
        .vec_len(vec_len), .enc_cls(enc_cls), .spec_fld(spec_fld), .wmask(wmask),
        .zero_en(zero_en), .old_dst(old_dst), .out_valid(out_valid), .new_dst(new_dst),
        .bad_enc(bad_enc), .invalid_op(invalid_op)
    );

    // Singles and their exact double images
    localparam logic [31:0] S_ONE = 32'h3F800000, S_M25 = 32'hC0200000, S_MAX = 32'h7F7FFFFF,
                            S_MIN = 32'h00800000, S_TINY = 32'h00000001, S_SUB1 = 32'h00400000,
                            S_SUB2 = 32'h00600000, S_PZ = 32'h00000000, S_NZ = 32'h80000000,
                            S_PI = 32'h7F800000, S_NI = 32'hFF800000, S_QN = 32'h7FC00000,
                            S_SN = 32'h7F800001;
    localparam logic [63:0] D_ONE = 64'h3FF0000000000000, D_M25 = 64'hC004000000000000,
                            D_MAX = 64'h47EFFFFFE0000000, D_MIN = 64'h3810000000000000,
                            D_TINY = 64'h36A0000000000000, D_SUB1 = 64'h3800000000000000,
                            D_SUB2 = 64'h3808000000000000, D_PZ = 64'h0, D_NZ = 64'h8000000000000000,
                            D_PI = 64'h7FF0000000000000, D_NI = 64'hFFF0000000000000,
                            D_QN = 64'h7FF8000000000000, D_SN = 64'h7FF8000020000000;

    task automatic check(input string req, input string what, input logic [511:0] act, input logic [511:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [511:0] old_pat();
        logic [511:0] r;
        for (int i = 0; i < 8; i++) r[64*i +: 64] = 64'hA5A5000000000000 | 64'(i);
        return r;
    endfunction

    // Drive one operand set for one cycle and return at the falling edge after the result loads.
    task automatic issue(input logic [1:0] cls, input logic [1:0] vl, input logic [3:0] sp,
                         input logic bc, input logic [7:0] wm, input logic zr,
                         input logic [255:0] s, input logic [511:0] od);
        @(negedge clk);
        enc_cls = cls; vec_len = vl; spec_fld = sp; bcast = bc; wmask = wm;
        zero_en = zr; src = s; old_dst = od; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R12", "out_valid after reset", {511'd0, out_valid}, '0);
        check("R12", "new_dst after reset", new_dst, '0);
        check("R12", "flags after reset", {510'd0, bad_enc, invalid_op}, '0);
    endtask

    task automatic t_normals();
        logic [255:0] s;
        logic [511:0] e, hold;
        s = {S_MIN, S_MAX, S_M25, S_ONE, S_MIN, S_MAX, S_M25, S_ONE};
        e = {D_MIN, D_MAX, D_M25, D_ONE, D_MIN, D_MAX, D_M25, D_ONE};
        issue(2'd1, 2'd2, 4'hF, 1'b0, 8'h00, 1'b0, s, old_pat());
        check("R2", "normals, 8 lanes", new_dst, e);
        check("R12", "out_valid one cycle later", {511'd0, out_valid}, 512'd1);
        hold = new_dst;
        @(negedge clk);
        check("R12", "out_valid drops", {511'd0, out_valid}, '0);
        check("R12", "new_dst holds while idle", new_dst, hold);
    endtask

    task automatic t_subnormals();
        logic [255:0] s;
        logic [511:0] e;
        s = '0; e = '0;
        s[127:0] = {S_SUB2, S_SUB1, S_TINY, S_TINY};
        e[255:0] = {D_SUB2, D_SUB1, D_TINY, D_TINY};
        issue(2'd1, 2'd1, 4'hF, 1'b0, 8'h00, 1'b0, s, old_pat());
        check("R3", "subnormals renormalised, R1 four lanes, R9 upper zero", new_dst, e);
    endtask

    task automatic t_specials();
        logic [255:0] s;
        logic [511:0] e;
        s = {S_SN, S_QN, S_NI, S_PI, S_NZ, S_PZ, S_QN, S_QN};
        e = {D_SN, D_QN, D_NI, D_PI, D_NZ, D_PZ, D_QN, D_QN};
        issue(2'd1, 2'd2, 4'hF, 1'b0, 8'h00, 1'b0, s, old_pat());
        check("R4", "zeros, infinities and NaNs (R5)", new_dst, e);
        check("R5", "signalling NaN raises invalid_op", {511'd0, invalid_op}, 512'd1);
        s[255:224] = S_QN;
        issue(2'd1, 2'd2, 4'hF, 1'b0, 8'h00, 1'b0, s, old_pat());
        check("R5", "quiet NaNs leave invalid_op low", {511'd0, invalid_op}, '0);
        s[255:224] = S_SN;
        issue(2'd2, 2'd2, 4'hF, 1'b0, 8'h7F, 1'b0, s, old_pat());
        check("R5", "signalling NaN in unwritten lane ignored", {511'd0, invalid_op}, '0);
    endtask

    task automatic t_bcast();
        logic [255:0] s;
        logic [511:0] e;
        s = {{7{S_ONE}}, S_M25};
        e = '0;
        for (int i = 0; i < 4; i++) e[64*i +: 64] = D_M25;
        issue(2'd1, 2'd1, 4'hF, 1'b1, 8'h00, 1'b0, s, old_pat());
        check("R6", "broadcast of lowest element", new_dst, e);
    endtask

    task automatic t_masked();
        logic [255:0] s;
        logic [511:0] e, o;
        s = {8{S_ONE}};
        o = old_pat();
        for (int i = 0; i < 8; i++) e[64*i +: 64] = 8'hA5 & (8'd1 << i) ? D_ONE : o[64*i +: 64];
        issue(2'd2, 2'd2, 4'hF, 1'b0, 8'hA5, 1'b0, s, o);
        check("R7", "merge masking", new_dst, e);
        for (int i = 0; i < 8; i++) e[64*i +: 64] = 8'hA5 & (8'd1 << i) ? D_ONE : 64'd0;
        issue(2'd2, 2'd2, 4'hF, 1'b0, 8'hA5, 1'b1, s, o);
        check("R7", "zero masking", new_dst, e);
        e = '0; e[63:0] = D_ONE;
        issue(2'd2, 2'd0, 4'hF, 1'b0, 8'hFD, 1'b0, s, o);
        e[127:64] = o[127:64];
        check("R9", "masked class clears above 128 bits", new_dst, e);
    endtask

    task automatic t_legacy_plain();
        logic [255:0] s;
        logic [511:0] e, o;
        s = {8{S_M25}};
        o = old_pat();
        e = o; e[127:0] = {D_M25, D_M25};
        issue(2'd0, 2'd2, 4'h0, 1'b0, 8'h00, 1'b1, s, o);
        check("R10", "legacy writes two lanes, keeps upper (R1, R8)", new_dst, e);
        check("R11", "legacy ignores spec field", {511'd0, bad_enc}, '0);
        e = {8{D_M25}};
        issue(2'd1, 2'd2, 4'hF, 1'b0, 8'h00, 1'b1, s, o);
        check("R8", "plain class ignores writemask", new_dst, e);
    endtask

    task automatic t_bad();
        logic [255:0] s;
        logic [511:0] o;
        s = {8{S_SN}};
        o = old_pat();
        issue(2'd1, 2'd2, 4'h7, 1'b0, 8'hFF, 1'b0, s, o);
        check("R11", "bad spec keeps destination", new_dst, o);
        check("R11", "bad spec flags", {510'd0, bad_enc, invalid_op}, 512'd2);
        issue(2'd3, 2'd0, 4'hF, 1'b0, 8'hFF, 1'b0, s, o);
        check("R11", "reserved class flagged", {511'd0, bad_enc}, 512'd1);
        issue(2'd2, 2'd3, 4'hF, 1'b0, 8'hFF, 1'b0, s, o);
        check("R11", "reserved length flagged", {511'd0, bad_enc}, 512'd1);
        check("R11", "reserved length keeps destination", new_dst, o);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normals();
        t_subnormals();
        t_specials();
        t_bcast();
        t_masked();
        t_legacy_plain();
        t_bad();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R12 watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule